// File: doc/BRIEF.md
# Byte Transmit Serializer with Interrupt Flags

This block turns bytes written by a host into a serial bit stream. A byte written to the data register waits in a one-byte holding register. The shift register takes it over on a bit-clock tick and sends it most significant bit first, one bit per tick. If another byte is already waiting when the last bit finishes, the shifter loads it on the tick that ends the current byte, so consecutive bytes go out with no gap.

The block tracks four transmit conditions as status flags: underflow, overflow, done and empty. Each flag is set and can be read whether or not its interrupt is enabled, so the host can poll. An enable register only masks the combined interrupt output. Done, overflow and underflow stay set until the host reads the status register. Empty stays set until the next data write. While the transmit-enable mode input is low, the shifter stays idle, all flags are cleared and the status register reads zero.

The register port is a plain synchronous read/write port. It has no back-pressure: a data write is always accepted, and a write that arrives while the holding register is still full replaces the waiting byte and raises overflow. The serial side has no handshake either. A new bit appears after every qualified tick.

Top module: `tx_serializer_irq`

## Requirements
- R1: After reset the enable and status registers read 0x00, `ser_active` and `ser_bit` are 0 and `irq` is 0.
- R2: A loaded byte is driven on `ser_bit` MSB first. Each bit holds until the next qualified tick (`bit_tick` high while `tx_en` is high). `ser_active` is 1 while a byte is in the shifter. `ser_bit` is 0 whenever `ser_active` is 0.
- R3: When a byte is waiting at the tick that ends the last bit, it is loaded on that same tick. `ser_active` stays 1 and its MSB follows with no idle cycle.
- R4: Empty (status bit 0) sets when the holding register moves into the shifter. A data-register write clears it, and the write wins if both happen in the same cycle. A status read does not clear it.
- R5: Overflow (status bit 2) sets on a data write while the holding register is full and is not being loaded in that cycle. The newest byte replaces the waiting byte.
- R6: Done (status bit 1) sets on the tick that ends a byte's last bit when no byte is waiting. The shifter then goes idle.
- R7: Underflow (status bit 3) sets on a qualified tick while the shifter is idle and nothing is waiting. It can set only after at least one bit has been sent since `tx_en` last went high.
- R8: A status read clears underflow, overflow and done. If a flag's set condition occurs in the same cycle as the read, the flag stays set.
- R9: Status bits set regardless of their enable bits. `irq` is the OR over bits 3:0 of (status AND enable).
- R10: With `tx_en` low the status register reads 0x00 and `irq` is 0. Ticks are ignored, the shifter is idle and all flags are cleared. After `tx_en` returns high, the flags start from zero.
- R11: Register map: 0x0D is the interrupt enable register (read/write, bits 3:0 stored, bits 7:4 read 0). 0x0E is the status register (read-only). 0x0F is the data register (write-only, reads 0). In both the enable and status registers, bit 3 is underflow, bit 2 overflow, bit 1 done and bit 0 empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit-enable mode |
| bit_tick | input | 1 | Bit-clock enable; one bit per tick |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status flags on a status read) |
| reg_addr | input | ADDR_W (8) | Register address |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Read data, combinational from `reg_addr` |
| ser_bit | output | 1 | Serial output bit |
| ser_active | output | 1 | A byte is being shifted |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit data width, which gives a three-bit bit counter that wraps at 7, and an 8-bit address. With these values the bench can hit the exact address values 0x0D to 0x0F and check the reserved upper nibble of both registers. Directed phases line up the tick that ends a byte against a waiting byte, against a second write and against a status read in the same cycle. A long random phase then toggles the mode input so that the rule requiring a bit to have been sent is retriggered many times.

// File: rtl/tx_ser_pkg.sv
`timescale 1ns/1ps
package tx_ser_pkg;
  localparam int FLAG_N    = 4;
  localparam int FL_EMPTY  = 0;
  localparam int FL_DONE   = 1;
  localparam int FL_OVF    = 2;
  localparam int FL_UNDER  = 3;
  localparam int ADR_IRQEN = 'h0D;
  localparam int ADR_STAT  = 'h0E;
  localparam int ADR_DATA  = 'h0F;
endpackage

// File: rtl/tx_shifter.sv
`timescale 1ns/1ps
module tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ser_bit,
  output logic              ser_active,
  output logic              load_ev,
  output logic              done_ev,
  output logic              under_ev,
  output logic              ovf_ev
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] hold_data, shreg;
  logic              hold_full, busy, sent_any;
  logic [CNT_W-1:0]  cnt;
  logic              step, at_last;

  always_comb begin
    step     = tx_en & bit_tick;
    at_last  = busy && (cnt == LAST);
    load_ev  = step && hold_full && (!busy || at_last);
    done_ev  = step && at_last && !hold_full;
    under_ev = step && !busy && !hold_full && sent_any;
    ovf_ev   = tx_en && data_wr && hold_full && !load_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_data <= '0;
      hold_full <= 1'b0;
      shreg     <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      sent_any  <= 1'b0;
    end else begin
      if (data_wr) begin
        hold_data <= wdata;
        hold_full <= 1'b1;
      end else if (load_ev) begin
        hold_full <= 1'b0;
      end
      if (!tx_en) begin
        shreg    <= '0;
        cnt      <= '0;
        busy     <= 1'b0;
        sent_any <= 1'b0;
      end else if (load_ev) begin
        shreg    <= hold_data;
        cnt      <= '0;
        busy     <= 1'b1;
        sent_any <= sent_any | busy;
      end else if (step && busy) begin
        sent_any <= 1'b1;
        if (at_last) begin
          busy <= 1'b0;
        end else begin
          shreg <= {shreg[DATA_W-2:0], 1'b0};
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end

  assign ser_bit    = busy & shreg[DATA_W-1];
  assign ser_active = busy;

  // R3: a byte waiting at the end of the last bit starts on the same tick
  a_r3_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && busy && cnt == LAST && hold_full) |=> (busy && cnt == '0));

  // R5: a write into a full, unloaded holding register replaces its content
  a_r5_newest_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && data_wr && hold_full && !(bit_tick && (!busy || cnt == LAST)))
    |=> (hold_full && hold_data == $past(wdata)));
endmodule

// File: rtl/tx_irq_flags.sv
`timescale 1ns/1ps
module tx_irq_flags
  import tx_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              load_ev,
  input  logic              done_ev,
  input  logic              under_ev,
  input  logic              ovf_ev,
  input  logic              data_wr,
  input  logic              stat_rd,
  input  logic              en_wr,
  input  logic [FLAG_N-1:0] en_wdata,
  output logic [FLAG_N-1:0] flags_vis,
  output logic [FLAG_N-1:0] en_q,
  output logic              irq
);
  logic [FLAG_N-1:0] flags;
  logic [FLAG_N-1:0] set_vec;

  always_comb begin
    set_vec           = '0;
    set_vec[FL_DONE]  = done_ev;
    set_vec[FL_OVF]   = ovf_ev;
    set_vec[FL_UNDER] = under_ev;
  end

  for (genvar gi = FL_DONE; gi < FLAG_N; gi++) begin : g_rdclr
    always_ff @(posedge clk) begin
      if (!rst_n || !tx_en) flags[gi] <= 1'b0;
      else                  flags[gi] <= set_vec[gi] | (flags[gi] & ~stat_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) flags[FL_EMPTY] <= 1'b0;
    else if (data_wr)     flags[FL_EMPTY] <= 1'b0;
    else                  flags[FL_EMPTY] <= flags[FL_EMPTY] | load_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata;
  end

  assign flags_vis = tx_en ? flags : '0;
  assign irq       = |(flags_vis & en_q);

  // R4: a data write leaves empty cleared
  a_r4_wr_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && data_wr) |=> !flags[FL_EMPTY]);

  // R4/R8: a status read without a write or load does not touch empty
  a_r8_read_keeps_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && stat_rd && !data_wr && !load_ev) |=> (flags[FL_EMPTY] == $past(flags[FL_EMPTY])));
endmodule

// File: rtl/tx_serializer_irq.sv
`timescale 1ns/1ps
module tx_serializer_irq
  import tx_ser_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ser_bit,
  output logic              ser_active,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADR_IRQEN);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(ADR_DATA);

  logic sel_en, sel_stat, sel_data;
  logic data_wr, en_wr, stat_rd;
  logic load_ev, done_ev, under_ev, ovf_ev;
  logic [FLAG_N-1:0] flags_vis, en_q;

  always_comb begin
    sel_en   = (reg_addr == A_EN);
    sel_stat = (reg_addr == A_STAT);
    sel_data = (reg_addr == A_DATA);
    data_wr  = reg_wr & sel_data;
    en_wr    = reg_wr & sel_en;
    stat_rd  = reg_rd & sel_stat;
  end

  tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .bit_tick   (bit_tick),
    .data_wr    (data_wr),
    .wdata      (reg_wdata),
    .ser_bit    (ser_bit),
    .ser_active (ser_active),
    .load_ev    (load_ev),
    .done_ev    (done_ev),
    .under_ev   (under_ev),
    .ovf_ev     (ovf_ev)
  );

  tx_irq_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .load_ev   (load_ev),
    .done_ev   (done_ev),
    .under_ev  (under_ev),
    .ovf_ev    (ovf_ev),
    .data_wr   (data_wr),
    .stat_rd   (stat_rd),
    .en_wr     (en_wr),
    .en_wdata  (reg_wdata[FLAG_N-1:0]),
    .flags_vis (flags_vis),
    .en_q      (en_q),
    .irq       (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_en)        reg_rdata[FLAG_N-1:0] = en_q;
    else if (sel_stat) reg_rdata[FLAG_N-1:0] = flags_vis;
  end

  // R10: mode low keeps the interrupt and status quiet
  a_r10_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (!irq && (!sel_stat || reg_rdata == '0)));

  // R6: done rises only as the shifter goes idle
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_vis[FL_DONE]) |-> !ser_active);

  // R11: reserved bits of the enable and status registers read zero
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en || sel_stat) |-> (reg_rdata[DATA_W-1:FLAG_N] == '0));

  // R2: no serial data while idle
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_active && !$past(ser_active)) |-> !ser_bit);
endmodule

// File: tb/test_tx_serializer_irq.sv
`timescale 1ns/1ps
module test_tx_serializer_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, bit_tick = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = 8'h0E, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ser_bit, ser_active, irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  string tag = "R1";

  // reference model state
  int       m_hold[$];
  int       m_sh = 0, m_cnt = 0;
  bit       m_busy = 0, m_sent = 0;
  bit [3:0] m_fl = 0, m_en = 0;

  always #4 clk = ~clk;

  tx_serializer_irq i_tx_serializer_irq (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ser_bit(ser_bit), .ser_active(ser_active), .irq(irq)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata();
    if (reg_addr == 8'h0D) return int'(m_en);
    if (reg_addr == 8'h0E) return tx_en ? int'(m_fl) : 0;
    return 0;
  endfunction

  task automatic compare();
    bit [3:0] vis;
    vis = tx_en ? m_fl : 4'h0;
    chk(tag, "rdata", int'(reg_rdata), exp_rdata());
    chk("R2", "ser_active", int'(ser_active), int'(m_busy));
    chk("R2", "ser_bit", int'(ser_bit), int'(m_busy && m_sh[7]));
    chk("R9", "irq", int'(irq), int'(|(vis & m_en)));
  endtask

  task automatic model_update();
    bit hf, stepb, atl, load, done, under, dwr, ovf, rdclr, nsent;
    hf = (m_hold.size() > 0);
    stepb = tx_en && bit_tick;
    atl = m_busy && (m_cnt == 7);
    load = 0; done = 0; under = 0;
    if (stepb) begin
      if (m_busy && !atl) begin m_sh = (m_sh << 1) & 255; m_cnt++; end
      else if (hf) load = 1;
      else if (m_busy) done = 1;
      else if (m_sent) under = 1;
    end
    nsent = tx_en ? (m_sent | (stepb && m_busy)) : 1'b0;
    dwr = reg_wr && reg_addr == 8'h0F;
    ovf = tx_en && dwr && hf && !load;
    rdclr = reg_rd && reg_addr == 8'h0E;
    if (load) begin m_sh = m_hold.pop_front(); m_cnt = 0; m_busy = 1; end
    if (done) m_busy = 0;
    if (dwr) begin m_hold.delete(); m_hold.push_back(int'(reg_wdata)); end
    if (!tx_en) begin m_busy = 0; m_cnt = 0; m_sh = 0; m_fl = 0; end
    else begin
      m_fl[3] = under | (m_fl[3] & !rdclr);
      m_fl[2] = ovf   | (m_fl[2] & !rdclr);
      m_fl[1] = done  | (m_fl[1] & !rdclr);
      m_fl[0] = dwr ? 1'b0 : (m_fl[0] | load);
    end
    if (reg_wr && reg_addr == 8'h0D) m_en = reg_wdata[3:0];
    m_sent = nsent;
  endtask

  // one cycle: drive after the falling edge, compare, clock, update model
  task automatic step(bit tk, bit wr, bit rd, logic [7:0] ad, logic [7:0] wd);
    bit_tick = tk; reg_wr = wr; reg_rd = rd; reg_addr = ad; reg_wdata = wd;
    #1 compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 8'h0E, 8'h00);
  endtask

  task automatic peek(logic [7:0] ad, string req, int exp);
    bit_tick = 0; reg_wr = 0; reg_rd = 0; reg_addr = ad;
    #1 chk(req, "peek rdata", int'(reg_rdata), exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    tag = "R1";
    peek(8'h0D, "R1", 0);
    peek(8'h0E, "R1", 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "ser_active", int'(ser_active), 0);
    step(0, 0, 0, 8'h0E, 0);

    tx_en = 1'b1;
    // R11: enable register keeps only bits 3:0; data register reads 0
    tag = "R11";
    step(0, 1, 0, 8'h0D, 8'hFF);
    peek(8'h0D, "R11", 'h0F);
    step(0, 1, 0, 8'h0F, 8'hA5);
    peek(8'h0F, "R11", 0);

    // R2/R4: load, MSB first, empty set
    tag = "R4";
    ticks(1);
    peek(8'h0E, "R4", 'h01);
    tag = "R2";
    for (int k = 7; k >= 0; k--) begin
      chk("R2", "bit order", int'(ser_bit), int'((8'hA5 >> k) & 1));
      ticks(1);
    end
    // R6: done, now idle
    tag = "R6";
    peek(8'h0E, "R6", 'h03);
    chk("R6", "idle after done", int'(ser_active), 0);
    // R7: underflow on the next idle tick
    tag = "R7";
    ticks(1);
    peek(8'h0E, "R7", 'h0B);
    // R8: status read clears all but empty
    tag = "R8";
    step(0, 0, 1, 8'h0E, 0);
    peek(8'h0E, "R8", 'h01);

    // R3/R5: back-to-back bytes and overflow
    tag = "R3";
    step(0, 1, 0, 8'h0F, 8'h3C);
    ticks(1);
    step(0, 1, 0, 8'h0F, 8'hC3);
    tag = "R5";
    step(0, 1, 0, 8'h0F, 8'h99);
    peek(8'h0E, "R5", 'h04);
    tag = "R3";
    for (int i = 0; i < 8; i++) ticks(1);
    chk("R3", "active across boundary", int'(ser_active), 1);
    chk("R3", "msb of next byte", int'(ser_bit), 1);
    ticks(8);
    step(0, 0, 1, 8'h0E, 0);
    // R8: underflow tick together with a status read keeps underflow
    tag = "R8";
    step(1, 0, 1, 8'h0E, 0);
    peek(8'h0E, "R8", 'h09);

    // R9: masking only touches irq
    tag = "R9";
    step(0, 1, 0, 8'h0D, 8'h00);
    chk("R9", "masked irq", int'(irq), 0);
    peek(8'h0E, "R9", 'h09);
    step(0, 1, 0, 8'h0D, 8'h08);
    chk("R9", "unmasked irq", int'(irq), 1);

    // R10: mode low
    tag = "R10";
    tx_en = 1'b0;
    peek(8'h0E, "R10", 0);
    chk("R10", "irq off", int'(irq), 0);
    ticks(5);
    tx_en = 1'b1;
    peek(8'h0E, "R10", 0);
    // R7: no underflow before a bit has been sent
    tag = "R7";
    ticks(4);
    peek(8'h0E, "R7", 0);

    // random traffic
    tag = "R8";
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if ($urandom_range(0, 199) == 0) tx_en = ~tx_en;
      if (r < 8)       step($urandom_range(0,1) == 1, 1, 0, 8'h0F, 8'($urandom));
      else if (r < 16) step($urandom_range(0,1) == 1, 0, 1, 8'h0E, 0);
      else if (r < 19) step($urandom_range(0,1) == 1, 1, 0, 8'h0D, 8'($urandom));
      else if (r < 22) step($urandom_range(0,1) == 1, 0, 0, 8'h0D, 0);
      else             step($urandom_range(0,1) == 1, 0, 0, 8'h0E, 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule